// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a set of interrupt request lines and presents one request at a time to a processor core, together with the index of the source that won. Each source has a pending flag, an enable bit and a small priority number. The block also has a global enable. A lower priority number is more urgent. A programmable split point divides each priority number into two parts. The upper bits form a preemption level, which decides whether one handler may interrupt another. The lower bits form a subpriority, which only orders pending sources that share a preemption level.

The core acknowledges the presented request. The controller then clears that source's pending flag and records the source's preemption level on an internal stack of active levels. A later request is presented while a handler runs only if its preemption level is strictly more urgent than the level on top of the stack. An end-of-service pulse pops the stack. Software configures the block and inspects it through a plain write/read register port.

Register map (word addresses):
- 0 is control. Bit 0 is the global enable. Bits [5:4] hold the split point.
- 1 is the enable mask, one bit per source.
- 2 is the pending flags. A read returns them; writing 1 to a bit clears that flag.
- 4+i holds the priority of source i in bits [2:0].

Top module: `prio_irq_ctrl`

## Requirements
- R1: A rising edge on request line i sets pending bit i one clock later. This happens whatever the global enable and enable mask hold. The flags read back at address 2, with bit i for source i.
- R2: Writing to address 2 clears each pending bit whose data bit is 1. Bits written as 0 keep their value.
- R3: While control bit 0 (global enable) is 0, irq_o stays low, whatever the mask holds.
- R4: A source can drive irq_o only while its mask bit (address 1, bit i) and the global enable are both 1.
- R5: The winner is the enabled pending source with the smallest priority number. Among sources with equal numbers, the lowest index wins. irq_id_o carries the winner's index.
- R6: A split value k in control bits [5:4] makes the upper k bits of the 3-bit priority the preemption level. With k = 0, every source has level 0.
- R7: While the active stack is empty, any winner raises irq_o. Otherwise the winner raises irq_o only if its preemption level is numerically lower than the level on top of the stack.
- R8: When ack_i is high while irq_o is high, the winner's pending bit clears and its level is pushed. An eoi_i pulse pops one level. eoi_i on an empty stack changes nothing.
- R9: The stack holds eight levels, enough for a full chain of nested handlers. After a pop, a request that was held back because its level was not more urgent is presented.
- R10: After reset, the control, mask, pending and priority registers read 0, the stack is empty and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_req_i | input | 8 | Interrupt request lines, captured on rising edge |
| irq_o | output | 1 | Request to the core |
| irq_id_o | output | 3 | Index of the presented source |
| ack_i | input | 1 | Core accepts the presented request |
| eoi_i | input | 1 | Core finished the innermost handler |

## Verification
The bench sweeps every pair of preemption numbers for a running and an arriving source under all four split values. This catches a non-strict comparison, which would let an equal level nest. It also catches an off-by-one in the split shift, which would let subpriority bits decide nesting. Where nesting is refused, the bench issues the end of service and expects the held request to appear. A controller that dropped pending flags on refusal would leave irq_o low there. Arbitration is checked against many hashed priority and mask patterns, including all-equal priorities, where a design that broke ties toward the high index would report the wrong source. A full eight-deep chain is built and unwound, with an extra end of service on the empty stack. A stack that wrapped or underflowed would afterwards block or wrongly grant requests.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ADDR_CTRL      = 0;
  localparam int unsigned ADDR_MASK      = 1;
  localparam int unsigned ADDR_PEND      = 2;
  localparam int unsigned ADDR_PRIO      = 4;
  localparam int unsigned CTRL_GEN_BIT   = 0;
  localparam int unsigned CTRL_SPLIT_LSB = 4;
endpackage

// File: rtl/pic_regs.sv
module pic_regs import pic_pkg::*; #(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned SPLIT_W = $clog2(PRIO_W + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [N_SRC-1:0]              req_i,
  input  logic                          ack_i,
  input  logic [IDX_W-1:0]              ack_idx_i,
  output logic                          gen_o,
  output logic [N_SRC-1:0]              mask_o,
  output logic [N_SRC-1:0]              pend_o,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [SPLIT_W-1:0]            split_o
);
  logic [N_SRC-1:0]             req_q, pend_q, mask_q;
  logic [N_SRC-1:0]             rise, ack_vec, sw_clr;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic                         gen_q;
  logic [SPLIT_W-1:0]           split_q, wsplit;
  logic                         unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign rise   = req_i & ~req_q;
  assign wsplit = wdata_i[CTRL_SPLIT_LSB +: SPLIT_W];
  assign sw_clr = (we_i && addr_i == ADDR_W'(ADDR_PEND)) ? wdata_i[N_SRC-1:0] : '0;

  always_comb begin
    ack_vec = '0;
    if (ack_i) ack_vec[ack_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      gen_q   <= 1'b0;
      split_q <= '0;
    end else begin
      req_q  <= req_i;
      // a new event wins over a clear in the same cycle
      pend_q <= (pend_q & ~(ack_vec | sw_clr)) | rise;
      if (we_i && addr_i == ADDR_W'(ADDR_CTRL)) begin
        gen_q   <= wdata_i[CTRL_GEN_BIT];
        split_q <= (wsplit > SPLIT_W'(PRIO_W)) ? SPLIT_W'(PRIO_W) : wsplit;
      end
      if (we_i && addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wdata_i[N_SRC-1:0];
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       prio_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(ADDR_PRIO + i)) prio_q[i] <= wdata_i[PRIO_W-1:0];
    end

    // R1
    pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(req_i[i]) |=> pend_q[i]);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) begin
      rdata_o[CTRL_GEN_BIT]                 = gen_q;
      rdata_o[CTRL_SPLIT_LSB +: SPLIT_W]    = split_q;
    end
    if (addr_i == ADDR_W'(ADDR_MASK)) rdata_o[N_SRC-1:0] = mask_q;
    if (addr_i == ADDR_W'(ADDR_PEND)) rdata_o[N_SRC-1:0] = pend_q;
    for (int i = 0; i < N_SRC; i++)
      if (addr_i == ADDR_W'(ADDR_PRIO + i)) rdata_o[PRIO_W-1:0] = prio_q[i];
  end

  assign gen_o   = gen_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;
  assign prio_o  = prio_q;
  assign split_o = split_q;
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             cand_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                         valid_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [PRIO_W-1:0]            prio_o
);
  // strict compare in ascending index order keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LVL_W = 3,
  localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [LVL_W-1:0] top_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [DEPTH-1:0][LVL_W-1:0] mem_q;
  logic [SP_W-1:0]             sp_q, sp_pop;
  logic                        pop_ok;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign sp_pop  = sp_q - SP_W'(pop_ok);
  assign top_o   = empty_o ? '0 : mem_q[sp_q - SP_W'(1)];

  // pop is applied before push when both arrive together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      sp_q  <= '0;
    end else begin
      if (push_i) mem_q[sp_pop] <= lvl_i;
      sp_q <= sp_pop + SP_W'(push_i);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> !full_o);

  // R7
  nest_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !empty_o |-> lvl_i < top_o);

  // R8
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && empty_o |=> empty_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned SPLIT_W = $clog2(PRIO_W + 1),
  localparam int unsigned DEPTH   = 1 << PRIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_SRC-1:0]  irq_req_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_id_o,
  input  logic              ack_i,
  input  logic              eoi_i
);
  logic                         gen;
  logic [N_SRC-1:0]             mask, pend, cand;
  logic [N_SRC-1:0][PRIO_W-1:0] prio;
  logic [SPLIT_W-1:0]           split, shamt;
  logic                         win_valid, ack_eff, stk_empty, stk_full;
  logic [IDX_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_prio, win_lvl, top_lvl;

  pic_regs #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .req_i(irq_req_i), .ack_i(ack_eff), .ack_idx_i(win_idx),
    .gen_o(gen), .mask_o(mask), .pend_o(pend), .prio_o(prio), .split_o(split)
  );

  assign cand = pend & mask & {N_SRC{gen}};

  pic_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .cand_i(cand), .prio_i(prio),
    .valid_o(win_valid), .idx_o(win_idx), .prio_o(win_prio)
  );

  // preemption level = upper split bits of the priority
  assign shamt   = SPLIT_W'(PRIO_W) - split;
  assign win_lvl = win_prio >> shamt;

  pic_stack #(.DEPTH(DEPTH), .LVL_W(PRIO_W)) u_stack (
    .clk_i, .rst_ni,
    .push_i(ack_eff), .pop_i(eoi_i), .lvl_i(win_lvl),
    .top_o(top_lvl), .empty_o(stk_empty), .full_o(stk_full)
  );

  assign irq_o    = win_valid && (stk_empty || win_lvl < top_lvl);
  assign irq_id_o = win_idx;
  assign ack_eff  = ack_i && irq_o;

  // R3
  irq_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gen);

  // R4
  irq_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask[irq_id_o] && pend[irq_id_o]);

  // R9
  irq_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !stk_full);

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    // R5
    win_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o && cand[i] |-> (prio[i] > win_prio) ||
                           (prio[i] == win_prio && IDX_W'(i) >= irq_id_o));
  end
endmodule

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  req = '0;
  logic        irq;
  logic [2:0]  id;
  logic        ack = 1'b0;
  logic        eoi = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_req_i(req),
    .irq_o(irq), .irq_id_o(id), .ack_i(ack), .eoi_i(eoi)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); addr = 5'(a); wdata = 32'(d); we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); addr = 5'(a); #1 d = int'(rdata);
  endtask

  task automatic pulse(input int m);
    @(negedge clk); req = 8'(m);
    @(negedge clk); req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask

  function automatic int irq_word();
    return irq ? 16 + int'(id) : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int d, best, bidx, m, exp;
    int p[8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(0, d); chk("R10 ctrl", d, 0);
    rd(1, d); chk("R10 mask", d, 0);
    rd(2, d); chk("R10 pend", d, 0);
    rd(7, d); chk("R10 prio", d, 0);
    chk("R10 irq", int'(irq), 0);

    // R1 latch while everything disabled
    pulse(8'hA5);
    rd(2, d); chk("R1 pend masked", d, 'hA5);
    chk("R1 no irq", int'(irq), 0);

    // R2 write-one-to-clear
    wr(2, 'h81);
    rd(2, d); chk("R2 clear ones", d, 'h24);
    wr(2, 0);
    rd(2, d); chk("R2 zero keeps", d, 'h24);

    // R3 / R4 gating
    wr(1, 'hFF);
    chk("R3 gen off", int'(irq), 0);
    wr(0, 1); wr(1, 0);
    chk("R4 mask off", int'(irq), 0);
    wr(1, 'h20);
    chk("R4 only src5", irq_word(), 16 + 5);
    wr(1, 'h24);
    chk("R5 tie low idx", irq_word(), 16 + 2);
    wr(0, 0);
    chk("R3 gen cleared", int'(irq), 0);

    // R6 split readback
    wr(0, 1 | (3 << 4));
    rd(0, d); chk("R6 ctrl readback", d, 'h31);

    // R5 arbitration sweep
    for (int t = 0; t < 40; t++) begin
      m = (t * 37 + 11) & 'hFF;
      if (t % 10 == 0) m = 0;
      for (int i = 0; i < 8; i++) begin
        p[i] = (i * i * 3 + t * 5 + i) % 8;
        if (t == 7) p[i] = 4;
        wr(4 + i, p[i]);
      end
      wr(1, m);
      wr(2, 'hFF);
      pulse(8'hFF);
      best = 99; bidx = -1;
      for (int i = 0; i < 8; i++)
        if (m[i] && p[i] < best) begin best = p[i]; bidx = i; end
      chk("R5 arb", irq_word(), (bidx < 0) ? 0 : 16 + bidx);
    end
    wr(2, 'hFF);

    // R6 R7 nesting sweep
    wr(1, 'h03);
    for (int k = 0; k < 4; k++) begin
      wr(0, 1 | (k << 4));
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          wr(4, a); wr(5, b);
          pulse(1);
          chk("R5 R8 first", irq_word(), 16);
          do_ack();
          rd(2, d); chk("R8 ack clears", d, 0);
          pulse(2);
          exp = ((b >> (3 - k)) < (a >> (3 - k))) ? 1 : 0;
          chk("R6 R7 nest", irq_word(), exp ? 17 : 0);
          if (exp != 0) begin
            do_ack(); do_eoi(); do_eoi();
          end else begin
            do_eoi();
            chk("R9 deferred", irq_word(), 17);
            do_ack(); do_eoi();
          end
          do_eoi();
          wr(2, 'hFF);
        end
      end
    end

    // R9 full-depth chain
    wr(0, 1 | (3 << 4));
    wr(1, 'hFF);
    for (int i = 0; i < 8; i++) wr(4 + i, 7 - i);
    for (int i = 0; i < 8; i++) begin
      pulse(1 << i);
      chk("R9 chain", irq_word(), 16 + i);
      do_ack();
    end
    pulse('h80);
    chk("R7 equal level", int'(irq), 0);
    do_eoi();
    chk("R9 after pop", irq_word(), 16 + 7);
    wr(2, 'hFF);
    for (int i = 0; i < 8; i++) do_eoi();
    pulse(1);
    chk("R8 empty after unwind", irq_word(), 16);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule